// File: doc/BRIEF.md
# Dual-Mode Post-Demodulation Filter and Data Slicer

This block recovers receive data bits from one of two sample streams. In frequency-shift mode it takes signed samples from a digital frequency discriminator, whose value follows the instantaneous IF frequency. In amplitude mode (ASK or on-off keying) it takes unsigned samples from the signal-strength ADC. A 2-bit mode field picks the stream. The chosen samples pass through a first-order low-pass averaging filter. The filter's cutoff is set by a 10-bit bandwidth word, which is the cutoff in radians per demodulator clock, scaled by 1024. For amplitude keying the cutoff is normally set near three quarters of the data rate, so that noise is removed without smearing adjacent symbols.

The filtered value feeds an envelope tracker. The tracker follows a running peak and a running trough, and each one relaxes slowly back toward the signal. The midpoint of the peak and trough is the decision threshold. The slicer compares each filtered value with that threshold and emits one data bit with a single-cycle valid strobe, meant for a downstream clock-recovery loop.

Two configuration words are written through a simple write port: the mode and the bandwidth. Any write clears the filter, the envelope and the pipeline.

Top module: `postdemod_filter`

## Requirements
- R1: After reset the mode is frequency-shift (00), the bandwidth word is 64, filt_out is 0, and data_out and data_valid are low.
- R2: In mode 00 a sample is taken from freq_sample (signed) on each clock edge where freq_valid is high. Strobes on rssi_valid have no effect on filt_out or data_valid.
- R3: In mode 10 a sample is taken from rssi_sample, treated as unsigned, on each clock edge where rssi_valid is high. Strobes on freq_valid have no effect.
- R4: At every accepted sample, an accumulator A holding the filtered value times 1024 is updated as A ← A + floor(((x·1024 − A)·bw)/1024), where x is the sample and bw is the bandwidth word. filt_out = floor(A/1024) is visible right after that edge.
- R5: A write with cfg_addr=1 sets the bandwidth word from cfg_wdata[9:0]. With a bandwidth word of 0, accepted samples leave filt_out unchanged.
- R6: At the first filtered value y after a clear, the peak and trough are both set to y. After that, the peak becomes y when y ≥ peak and otherwise becomes peak − floor((peak−y)/16). The trough becomes y when y ≤ trough and otherwise becomes trough + floor((y−trough)/16).
- R7: A sample accepted at edge k produces a data_valid pulse of one cycle after edge k+2. At the same time data_out becomes 1 when y > floor((peak+trough)/2), using the envelope already updated with y, and 0 otherwise. data_out holds its value between strobes.
- R8: Modes 01 and 11 are reserved. In them no sample is accepted, filt_out stays 0, data_out is low and data_valid never rises.
- R9: Any write (cfg_we high; cfg_addr=0 sets the mode from cfg_wdata[1:0]) clears the accumulator, the envelope, the pending pipeline and data_out at that edge. A sample strobed at the same edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Demodulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects the mode word, 1 selects the bandwidth word |
| cfg_wdata | input | 10 | Write data |
| freq_valid | input | 1 | Discriminator sample strobe |
| freq_sample | input | 12 | Signed discriminator sample |
| rssi_valid | input | 1 | Signal-strength sample strobe |
| rssi_sample | input | 8 | Unsigned signal-strength sample |
| filt_out | output | 12 | Signed filtered value |
| data_out | output | 1 | Recovered data bit |
| data_valid | output | 1 | Single-cycle strobe for a new data bit |

## Verification
A sample driven before edge k changes filt_out right after edge k. It raises data_valid, together with the new data_out, only after edge k+2. A configuration write clears every output right after its own edge. The bench drives each stimulus on a falling edge and checks filt_out on the falling edge after the accepting edge. It then checks on the next falling edge that data_valid is still low, and on the one after that that data_valid is high with the data bit. An independent arithmetic model in the bench supplies the expected filtered value and the expected decision.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    typedef enum logic [1:0] {
        MODE_FSK  = 2'b00,
        MODE_RSV1 = 2'b01,
        MODE_ASK  = 2'b10,
        MODE_RSV3 = 2'b11
    } demod_mode_e;

    localparam logic CFG_SEL_MODE = 1'b0;
    localparam logic CFG_SEL_BW   = 1'b1;

    function automatic logic mode_live(input demod_mode_e m);
        return (m == MODE_FSK) || (m == MODE_ASK);
    endfunction

endpackage

// File: rtl/pdf_cfg.sv
module pdf_cfg
    import pdf_pkg::*;
#(
    parameter int BW_W     = 10,
    parameter int BW_RESET = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            sel,
    input  logic [BW_W-1:0] wdata,
    output demod_mode_e     mode_o,
    output logic [BW_W-1:0] bw_o,
    output logic            clr_o
);

    typedef struct packed {
        demod_mode_e     mode;
        logic [BW_W-1:0] bw;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (sel == CFG_SEL_MODE) begin
                cfg_d.mode = demod_mode_e'(wdata[1:0]);
            end else begin
                cfg_d.bw = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode <= MODE_FSK;
            cfg_q.bw   <= BW_W'(BW_RESET);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o = cfg_q.mode;
    assign bw_o   = cfg_q.bw;
    assign clr_o  = we;

endmodule

// File: rtl/pdf_lpf.sv
module pdf_lpf
    import pdf_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int RSSI_W   = 8,
    parameter int BW_W     = 10,
    parameter int FRAC_W   = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  demod_mode_e                mode,
    input  logic [BW_W-1:0]            bw,
    input  logic                       freq_valid,
    input  logic signed [SAMPLE_W-1:0] freq_sample,
    input  logic                       rssi_valid,
    input  logic [RSSI_W-1:0]          rssi_sample,
    output logic signed [SAMPLE_W-1:0] y_o,
    output logic                       y_vld_o
);

    localparam int AW  = SAMPLE_W + FRAC_W;
    localparam int DW  = AW + 1;
    localparam int PW  = DW + BW_W + 1;
    localparam int PAD = SAMPLE_W - RSSI_W;

    typedef struct packed {
        logic signed [AW-1:0] acc;
        logic                 vld;
    } lpf_t;

    lpf_t st_d, st_q;

    logic                       take;
    logic signed [SAMPLE_W-1:0] x_sel;
    logic signed [AW-1:0]       x_acc;
    logic signed [DW-1:0]       diff;
    logic signed [BW_W:0]       bw_s;
    logic signed [PW-1:0]       prod;
    logic signed [PW-1:0]       step;

    // Input source selection: the amplitude stream is unsigned and is
    // zero-extended into the signed sample width.
    generate
        if (PAD > 0) begin : g_pad
            logic signed [SAMPLE_W-1:0] rssi_ext;
            assign rssi_ext = $signed({{PAD{1'b0}}, rssi_sample});
            assign x_sel = (mode == MODE_ASK) ? rssi_ext : freq_sample;
        end else begin : g_nopad
            assign x_sel = (mode == MODE_ASK) ? $signed(rssi_sample) : freq_sample;
        end
    endgenerate

    always_comb begin
        take  = !clr && (((mode == MODE_FSK) && freq_valid) ||
                         ((mode == MODE_ASK) && rssi_valid));
        x_acc = {x_sel, {FRAC_W{1'b0}}};
        diff  = {x_acc[AW-1], x_acc} - {st_q.acc[AW-1], st_q.acc};
        bw_s  = $signed({1'b0, bw});
        prod  = PW'(diff) * PW'(bw_s);
        step  = prod >>> BW_W;

        st_d     = st_q;
        st_d.vld = take;
        if (clr) begin
            st_d.acc = '0;
        end else if (take) begin
            st_d.acc = st_q.acc + step[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_o     = st_q.acc[AW-1:FRAC_W];
    assign y_vld_o = st_q.vld;

    AST_ZERO_BW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && bw == '0) |=> $stable(st_q.acc)); // R5

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.acc == '0 && !st_q.vld)); // R9

endmodule

// File: rtl/pdf_env.sv
module pdf_env #(
    parameter int SAMPLE_W = 12,
    parameter int DECAY_SH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic signed [SAMPLE_W-1:0] y,
    input  logic                       y_vld,
    output logic signed [SAMPLE_W-1:0] thr_o,
    output logic signed [SAMPLE_W-1:0] y2_o,
    output logic                       vld2_o
);

    localparam int EW = SAMPLE_W + 1;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] hi;
        logic signed [SAMPLE_W-1:0] lo;
        logic                       live;
        logic signed [SAMPLE_W-1:0] y2;
        logic                       vld2;
    } env_t;

    env_t st_d, st_q;

    logic signed [EW-1:0] y_e, hi_e, lo_e;
    logic signed [EW-1:0] hi_gap, lo_gap, hi_dec, lo_rise, mid_sum;

    always_comb begin
        y_e     = {y[SAMPLE_W-1], y};
        hi_e    = {st_q.hi[SAMPLE_W-1], st_q.hi};
        lo_e    = {st_q.lo[SAMPLE_W-1], st_q.lo};
        hi_gap  = (hi_e - y_e) >>> DECAY_SH;
        lo_gap  = (y_e - lo_e) >>> DECAY_SH;
        hi_dec  = hi_e - hi_gap;
        lo_rise = lo_e + lo_gap;
        mid_sum = (hi_e + lo_e) >>> 1;

        st_d      = st_q;
        st_d.vld2 = y_vld && !clr;
        if (clr) begin
            st_d = '0;
        end else if (y_vld) begin
            st_d.y2 = y;
            if (!st_q.live) begin
                st_d.hi   = y;
                st_d.lo   = y;
                st_d.live = 1'b1;
            end else begin
                st_d.hi = (y >= st_q.hi) ? y : hi_dec[SAMPLE_W-1:0];
                st_d.lo = (y <= st_q.lo) ? y : lo_rise[SAMPLE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_o  = mid_sum[SAMPLE_W-1:0];
    assign y2_o   = st_q.y2;
    assign vld2_o = st_q.vld2;

    AST_ENV_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live |-> (st_q.hi >= st_q.lo)); // R6

endmodule

// File: rtl/pdf_slicer.sv
module pdf_slicer #(
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       idle_mode,
    input  logic signed [SAMPLE_W-1:0] y2,
    input  logic signed [SAMPLE_W-1:0] thr,
    input  logic                       vld2,
    output logic                       data_o,
    output logic                       valid_o
);

    typedef struct packed {
        logic data;
        logic valid;
    } slc_t;

    slc_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = vld2 && !clr && !idle_mode;
        if (clr || idle_mode) begin
            st_d.data = 1'b0;
        end else if (vld2) begin
            st_d.data = (y2 > thr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/postdemod_filter.sv
module postdemod_filter
    import pdf_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int RSSI_W   = 8,
    parameter int BW_W     = 10,
    parameter int FRAC_W   = 10,
    parameter int DECAY_SH = 4,
    parameter int BW_RESET = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic                       cfg_addr,
    input  logic [BW_W-1:0]            cfg_wdata,
    input  logic                       freq_valid,
    input  logic signed [SAMPLE_W-1:0] freq_sample,
    input  logic                       rssi_valid,
    input  logic [RSSI_W-1:0]          rssi_sample,
    output logic signed [SAMPLE_W-1:0] filt_out,
    output logic                       data_out,
    output logic                       data_valid
);

    demod_mode_e                mode;
    logic [BW_W-1:0]            bw;
    logic                       clr;
    logic signed [SAMPLE_W-1:0] y, y2, thr;
    logic                       y_vld, vld2;
    logic                       idle_mode;

    assign idle_mode = !mode_live(mode);

    pdf_cfg #(.BW_W(BW_W), .BW_RESET(BW_RESET)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_addr),
        .wdata  (cfg_wdata),
        .mode_o (mode),
        .bw_o   (bw),
        .clr_o  (clr)
    );

    pdf_lpf #(
        .SAMPLE_W(SAMPLE_W), .RSSI_W(RSSI_W), .BW_W(BW_W), .FRAC_W(FRAC_W)
    ) u_lpf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .mode        (mode),
        .bw          (bw),
        .freq_valid  (freq_valid),
        .freq_sample (freq_sample),
        .rssi_valid  (rssi_valid),
        .rssi_sample (rssi_sample),
        .y_o         (y),
        .y_vld_o     (y_vld)
    );

    pdf_env #(.SAMPLE_W(SAMPLE_W), .DECAY_SH(DECAY_SH)) u_env (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .y      (y),
        .y_vld  (y_vld),
        .thr_o  (thr),
        .y2_o   (y2),
        .vld2_o (vld2)
    );

    pdf_slicer #(.SAMPLE_W(SAMPLE_W)) u_slc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .idle_mode (idle_mode),
        .y2        (y2),
        .thr       (thr),
        .vld2      (vld2),
        .data_o    (data_out),
        .valid_o   (data_valid)
    );

    assign filt_out = y;

    AST_RESERVED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_mode |-> !data_valid); // R8

    AST_RESERVED_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        idle_mode |-> !data_out); // R8

    AST_RESERVED_FILT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        idle_mode |-> (filt_out == '0)); // R8

endmodule

// File: tb/postdemod_filter_test.sv
module postdemod_filter_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic              cfg_addr = 1'b0;
    logic [9:0]        cfg_wdata = '0;
    logic              freq_valid = 1'b0;
    logic signed [11:0] freq_sample = '0;
    logic              rssi_valid = 1'b0;
    logic [7:0]        rssi_sample = '0;
    logic signed [11:0] filt_out;
    logic              data_out;
    logic              data_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    longint m_acc = 0, m_hi = 0, m_lo = 0, m_set = 64;
    bit     m_live = 0, m_data = 0, m_bw_written = 0;
    int     m_mode = 0;

    always #5 clk = ~clk;

    postdemod_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .freq_valid(freq_valid), .freq_sample(freq_sample),
        .rssi_valid(rssi_valid), .rssi_sample(rssi_sample), .filt_out(filt_out),
        .data_out(data_out), .data_valid(data_valid)
    );

    // op codes: 0 mode write, 1 bandwidth write, 2 freq sample, 3 rssi sample
    localparam int NV = 34;
    localparam logic [15:0] VEC [NV] = '{
        {2'd2, 2'd0, 12'(1000)}, {2'd2, 2'd0, 12'(1000)}, {2'd1, 2'd0, 12'(256)},
        {2'd2, 2'd0, 12'(400)},  {2'd2, 2'd0, 12'(400)},  {2'd2, 2'd0, 12'(400)},
        {2'd2, 2'd0, 12'(-300)}, {2'd2, 2'd0, 12'(-300)}, {2'd2, 2'd0, 12'(-300)},
        {2'd2, 2'd0, 12'(500)},  {2'd3, 2'd0, 12'(200)},  {2'd2, 2'd0, 12'(-800)},
        {2'd0, 2'd0, 12'(2)},    {2'd3, 2'd0, 12'(255)},  {2'd3, 2'd0, 12'(255)},
        {2'd3, 2'd0, 12'(0)},    {2'd3, 2'd0, 12'(0)},    {2'd3, 2'd0, 12'(255)},
        {2'd2, 2'd0, 12'(100)},  {2'd3, 2'd0, 12'(10)},   {2'd1, 2'd0, 12'(1023)},
        {2'd3, 2'd0, 12'(200)},  {2'd3, 2'd0, 12'(0)},    {2'd1, 2'd0, 12'(0)},
        {2'd3, 2'd0, 12'(250)},  {2'd0, 2'd0, 12'(1)},    {2'd3, 2'd0, 12'(100)},
        {2'd2, 2'd0, 12'(100)},  {2'd0, 2'd0, 12'(3)},    {2'd2, 2'd0, 12'(50)},
        {2'd0, 2'd0, 12'(0)},    {2'd2, 2'd0, 12'(2047)}, {2'd2, 2'd0, 12'(-2048)},
        {2'd2, 2'd0, 12'(2047)}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint m_y();
        return m_acc >>> 10;
    endfunction

    task automatic model_clear();
        m_acc = 0; m_hi = 0; m_lo = 0; m_live = 0; m_data = 0;
    endtask

    task automatic model_step(input longint x);
        longint y, thr;
        m_acc = m_acc + ((((x <<< 10) - m_acc) * m_set) >>> 10);
        y = m_y();
        if (!m_live) begin
            m_hi = y; m_lo = y; m_live = 1;
        end else begin
            m_hi = (y >= m_hi) ? y : m_hi - ((m_hi - y) >>> 4);
            m_lo = (y <= m_lo) ? y : m_lo + ((y - m_lo) >>> 4);
        end
        thr = (m_hi + m_lo) >>> 1;
        m_data = (y > thr);
    endtask

    task automatic cfg_write(input bit sel, input logic [9:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = sel; cfg_wdata = val;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        model_clear();
        if (sel) begin m_set = val; m_bw_written = 1; end
        else m_mode = val[1:0];
        chk(filt_out == 0, "R9 filt cleared", filt_out, 0);
        chk(data_out == 0, "R9 data cleared", data_out, 0);
        chk(data_valid == 0, "R9 no strobe", data_valid, 0);
    endtask

    task automatic push(input bit is_rssi, input logic [11:0] val);
        bit    acc;
        string tg;
        @(negedge clk);
        if (is_rssi) begin rssi_valid = 1'b1; rssi_sample = val[7:0]; end
        else begin freq_valid = 1'b1; freq_sample = val; end
        @(posedge clk);
        @(negedge clk);
        rssi_valid = 1'b0; freq_valid = 1'b0;
        acc = (m_mode == 0 && !is_rssi) || (m_mode == 2 && is_rssi);
        if (acc) model_step(is_rssi ? longint'(val[7:0]) : longint'($signed(val)));
        if (m_mode == 1 || m_mode == 3) tg = "R8";
        else if (!acc) tg = (m_mode == 0) ? "R2 ignored" : "R3 ignored";
        else if (m_set == 0) tg = "R5 frozen";
        else if (!m_bw_written) tg = "R1 R4 reset bandwidth";
        else tg = (m_mode == 2) ? "R3 R4" : "R2 R4";
        chk(longint'(filt_out) == m_y(), tg, filt_out, m_y());
        @(negedge clk);
        chk(data_valid == 0, "R7 early strobe", data_valid, 0);
        @(negedge clk);
        chk(data_valid == acc, acc ? "R7 strobe" : tg, data_valid, acc);
        chk(data_out == m_data, (m_mode == 1 || m_mode == 3) ? "R8 data low" : "R6 R7 decision",
            data_out, m_data);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(filt_out == 0, "R1 filt", filt_out, 0);
        chk(data_out == 0, "R1 data", data_out, 0);
        chk(data_valid == 0, "R1 strobe", data_valid, 0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][15:14])
                2'd0: cfg_write(1'b0, VEC[i][9:0]);
                2'd1: cfg_write(1'b1, VEC[i][9:0]);
                2'd2: push(1'b0, VEC[i][11:0]);
                default: push(1'b1, VEC[i][11:0]);
            endcase
        end

        // R9: a sample strobed on the same edge as a write is dropped
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 10'd512;
        freq_valid = 1'b1; freq_sample = 12'sd1500;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; freq_valid = 1'b0;
        model_clear(); m_set = 512;
        chk(filt_out == 0, "R9 same-edge sample dropped", filt_out, 0);
        repeat (2) @(negedge clk);
        chk(data_valid == 0, "R9 same-edge no strobe", data_valid, 0);
        push(1'b0, 12'(1500));
        push(1'b0, 12'(-1500));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule